// File: doc/BRIEF.md
# ADC Scan Sequencer

This block drives a multi-channel successive-approximation converter through programmed scans. A scan visits every enabled channel once, lowest number first. Each visit holds a sampling window whose length is set per channel, then issues a one-cycle start to the converter core and waits for its done strobe. The 12-bit value that comes back is stored in that channel's result slot. Starts come from a software, timer or external trigger pulse. A per-group selector picks which of the three sources a group listens to.

Four modes are offered. Single mode runs one pass and stops. Continuous mode restarts at the first channel after every pass. Group mode splits the channels into two sets, A and B, each with its own trigger; A takes priority. Double mode converts one chosen channel on successive triggers and keeps the first and second results in separate registers. The converter core is reached through a plain start/channel/done/result handshake, so the analog part can be any model or macro.

Top module: `adc_scan_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets: busy_o, sample_o, core_start_o and both scan-done outputs read 0, and every result register, including res_dbl_o, reads 0.
- R2: Each group starts only from the trigger chosen by its 2-bit selector (0 software, 1 timer, 2 external, 3 none). Pulses on the other sources have no effect.
- R3: A pass converts every enabled channel exactly once, in ascending channel number. core_chan_o shows the channel while its sampling window and its core_start_o pulse are present.
- R4: Before each conversion, sample_o is high for N+1 consecutive cycles, where N is the channel's field samp_time_i[ch*SAMP_W +: SAMP_W]. The next cycle carries a single-cycle core_start_o.
- R5: The core_result_i value present with core_done_i is stored in res_data_o[ch*12 +: 12] of the channel being converted. It is visible from the cycle after the strobe, and other slots keep their values.
- R6: One cycle after the last enabled channel's result is accepted, the group's scan-done output (scan_done_a_o for group A and the single, continuous and double modes; scan_done_b_o for group B) is high for one cycle. In single mode (mode_i = 0) the block then goes idle.
- R7: In continuous mode (mode_i = 1), the next pass starts at the first enabled channel with no idle cycle. Scanning stops at the end of a pass during which mode_i no longer selects continuous.
- R8: A trigger for a group that is already scanning is ignored. A trigger for a group with no enabled channel is ignored.
- R9: In group mode (mode_i = 2), group A scans chan_en_a_i and group B scans chan_en_b_i. A B trigger during an A scan is held, and B runs its full pass right after A's pass. Simultaneous A and B triggers from idle run A first.
- R10: If a group A trigger arrives while group B scans, B stops after its current conversion, A runs a full pass, and B then restarts from its first channel. scan_done_b_o pulses only for B's complete pass.
- R11: In double mode (mode_i = 3), each trigger converts channel dbl_chan_i once. Odd-numbered triggers since entering the mode write res_data_o for that channel, even-numbered ones write res_dbl_o, and scan_done_a_o pulses after each conversion.
- R12: No new core_start_o is issued while a conversion is still awaiting its core_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 single, 1 continuous, 2 group, 3 double |
| chan_en_a_i | input | NCH | Channels of the main scan / group A |
| chan_en_b_i | input | NCH | Channels of group B (group mode only) |
| dbl_chan_i | input | CH_W | Channel used in double mode |
| samp_time_i | input | NCH*SAMP_W | Per-channel sampling length field |
| trig_src_a_i | input | 2 | Trigger source selector for group A |
| trig_src_b_i | input | 2 | Trigger source selector for group B |
| sw_trig_i | input | 1 | Software trigger pulse |
| tmr_trig_i | input | 1 | Timer trigger pulse |
| ext_trig_i | input | 1 | External trigger pulse |
| core_start_o | output | 1 | One-cycle conversion start to the core |
| core_chan_o | output | CH_W | Channel being sampled or converted |
| core_done_i | input | 1 | Conversion done strobe from the core |
| core_result_i | input | RES_W | Conversion value, valid with core_done_i |
| sample_o | output | 1 | Sampling window active |
| busy_o | output | 1 | A scan is in progress |
| scan_done_a_o | output | 1 | Pass of group A / main scan complete |
| scan_done_b_o | output | 1 | Pass of group B complete |
| res_data_o | output | NCH*RES_W | Per-channel result registers |
| res_dbl_o | output | RES_W | Second result of double mode |

## Verification
The hardest case to reach from the ports is a group A trigger that lands while a group B conversion is in flight, at a known position inside B's pass. That includes B's last channel, where B would otherwise have finished. The bench counts core_start_o pulses from its behavioural core and fires the A trigger after a chosen number of B starts. It then expects a B prefix, a full A pass and a full B pass from the start, in that order. Queued B triggers, simultaneous triggers and the switch out of continuous mode are set up with directed timing. Random masks, sampling lengths and trigger sources cover the ordinary passes.

// File: rtl/adc_scan_pkg.sv
// Shared encodings for the ADC scan sequencer.
// Assumes: mode and source codes are fixed by the port description.
package adc_scan_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_GROUP  = 2'd2,
        MODE_DOUBLE = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_NONE = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAMP  = 2'd1,
        ST_START = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    typedef enum logic {
        GRP_A = 1'b0,
        GRP_B = 1'b1
    } grp_e;

endpackage

// File: rtl/adc_trig_sel.sv
// Trigger source selector: routes one of three trigger pulses to a group.
// Assumes: trigger inputs are single-cycle pulses already synchronous to clk.
module adc_trig_sel
    import adc_scan_pkg::*;
(
    input  logic [1:0] src_i,
    input  logic       sw_i,
    input  logic       tmr_i,
    input  logic       ext_i,
    output logic       trig_o
);

    // Pick the pulse of the chosen source; code 3 disables the group.
    always_comb begin
        unique case (trig_src_e'(src_i))
            SRC_SW:   trig_o = sw_i;
            SRC_TMR:  trig_o = tmr_i;
            SRC_EXT:  trig_o = ext_i;
            SRC_NONE: trig_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_chan_pick.sv
// Lowest-set-bit finder: returns the smallest channel number in a candidate mask.
// Assumes: the caller masks off channels that are not eligible.
module adc_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  cand_i,
    output logic            found_o,
    output logic [CH_W-1:0] idx_o
);

    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = CH_W'(i);
            end
        end
    end

    assign found_o = |cand_i;

endmodule

// File: rtl/adc_samp_timer.sv
// Sampling window down-counter: loaded with N, expires after N+1 run cycles.
// Assumes: load and run are never high in the same cycle.
module adc_samp_timer #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SAMP_W-1:0] load_val_i,
    input  logic              run_i,
    output logic              expired_o
);

    logic [SAMP_W-1:0] cnt_q;

    // Count down toward zero while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/adc_result_bank.sv
// Result storage: one register per channel plus the second double-mode value.
// Assumes: at most one of the two write enables is high in a cycle.
module adc_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 wr_dbl_i,
    input  logic [CH_W-1:0]      ch_i,
    input  logic [RES_W-1:0]     data_i,
    output logic [NCH*RES_W-1:0] res_o,
    output logic [RES_W-1:0]     dbl_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [RES_W-1:0] slot_q;

        // Capture the core value when this channel's conversion completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_i && (ch_i == CH_W'(g))) begin
                slot_q <= data_i;
            end
        end

        assign res_o[g*RES_W +: RES_W] = slot_q;
    end

    logic [RES_W-1:0] dbl_q;

    // Hold the second result of a double-mode pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q <= '0;
        end else if (wr_dbl_i) begin
            dbl_q <= data_i;
        end
    end

    assign dbl_o = dbl_q;

endmodule

// File: rtl/adc_scan_seq.sv
// ADC scan sequencer top: trigger arbitration, channel stepping, sampling
// windows, group priority and result capture for a SAR converter core.
// Assumes: the core answers every core_start_o with exactly one core_done_i
// at least one cycle later; mode_i changes only between scans, except the
// move out of continuous mode, which takes effect at the end of a pass.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int RES_W  = 12,
    parameter int SAMP_W = 8,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [NCH-1:0]       chan_en_a_i,
    input  logic [NCH-1:0]       chan_en_b_i,
    input  logic [CH_W-1:0]      dbl_chan_i,
    input  logic [NCH*SAMP_W-1:0] samp_time_i,
    input  logic [1:0]           trig_src_a_i,
    input  logic [1:0]           trig_src_b_i,
    input  logic                 sw_trig_i,
    input  logic                 tmr_trig_i,
    input  logic                 ext_trig_i,
    output logic                 core_start_o,
    output logic [CH_W-1:0]      core_chan_o,
    input  logic                 core_done_i,
    input  logic [RES_W-1:0]     core_result_i,
    output logic                 sample_o,
    output logic                 busy_o,
    output logic                 scan_done_a_o,
    output logic                 scan_done_b_o,
    output logic [NCH*RES_W-1:0] res_data_o,
    output logic [RES_W-1:0]     res_dbl_o
);

    scan_mode_e mode;
    assign mode = scan_mode_e'(mode_i);

    // ---------------- state ----------------
    seq_state_e      state_q, state_d;
    grp_e            grp_q, grp_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic            pend_a_q, pend_a_d;
    logic            pend_b_q, pend_b_d;
    logic            dbl_ph_q, dbl_ph_d;
    logic            done_a_q, done_a_d;
    logic            done_b_q, done_b_d;

    // ---------------- channel sets ----------------
    logic [NCH-1:0] dbl_mask, set_a, set_b, cur_set, low_incl, next_cand;

    assign dbl_mask = NCH'(1) << dbl_chan_i;
    assign set_a    = (mode == MODE_DOUBLE) ? dbl_mask : chan_en_a_i;
    assign set_b    = (mode == MODE_GROUP) ? chan_en_b_i : '0;
    assign cur_set  = (grp_q == GRP_B) ? set_b : set_a;
    // Channels at or below the current one; wraps to all ones at the top channel.
    assign low_incl  = (NCH'(2) << ch_q) - NCH'(1);
    assign next_cand = cur_set & ~low_incl;

    logic            first_a_found, first_b_found, next_found;
    logic [CH_W-1:0] first_a, first_b, next_ch;

    adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick_a (
        .cand_i  (set_a),
        .found_o (first_a_found),
        .idx_o   (first_a)
    );

    adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick_b (
        .cand_i  (set_b),
        .found_o (first_b_found),
        .idx_o   (first_b)
    );

    adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick_next (
        .cand_i  (next_cand),
        .found_o (next_found),
        .idx_o   (next_ch)
    );

    // ---------------- triggers ----------------
    logic trig_a, trig_b_raw, trig_b, a_go, b_go;

    adc_trig_sel u_trig_a (
        .src_i  (trig_src_a_i),
        .sw_i   (sw_trig_i),
        .tmr_i  (tmr_trig_i),
        .ext_i  (ext_trig_i),
        .trig_o (trig_a)
    );

    adc_trig_sel u_trig_b (
        .src_i  (trig_src_b_i),
        .sw_i   (sw_trig_i),
        .tmr_i  (tmr_trig_i),
        .ext_i  (ext_trig_i),
        .trig_o (trig_b_raw)
    );

    assign trig_b = trig_b_raw && (mode == MODE_GROUP);
    assign a_go   = trig_a && first_a_found;
    assign b_go   = trig_b && first_b_found;

    // ---------------- sampling timer ----------------
    logic              enter_samp, samp_expired;
    logic [SAMP_W-1:0] samp_load;

    assign samp_load = samp_time_i[ch_d*SAMP_W +: SAMP_W];

    adc_samp_timer #(.SAMP_W(SAMP_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (enter_samp),
        .load_val_i (samp_load),
        .run_i      (state_q == ST_SAMP),
        .expired_o  (samp_expired)
    );

    // ---------------- result capture ----------------
    logic res_wr, res_wr_dbl;

    adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (res_wr),
        .wr_dbl_i (res_wr_dbl),
        .ch_i     (ch_q),
        .data_i   (core_result_i),
        .res_o    (res_data_o),
        .dbl_o    (res_dbl_o)
    );

    // Next-state logic: arbitration, channel stepping, pass completion.
    always_comb begin
        state_d    = state_q;
        grp_d      = grp_q;
        ch_d       = ch_q;
        pend_a_d   = pend_a_q;
        pend_b_d   = pend_b_q;
        dbl_ph_d   = (mode == MODE_DOUBLE) ? dbl_ph_q : 1'b0;
        done_a_d   = 1'b0;
        done_b_d   = 1'b0;
        enter_samp = 1'b0;
        res_wr     = 1'b0;
        res_wr_dbl = 1'b0;

        // Cross-group requests are held while the other group scans.
        if (state_q != ST_IDLE) begin
            if ((grp_q == GRP_B) && a_go) pend_a_d = 1'b1;
            if ((grp_q == GRP_A) && b_go) pend_b_d = 1'b1;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (a_go) begin
                    grp_d      = GRP_A;
                    ch_d       = first_a;
                    enter_samp = 1'b1;
                    state_d    = ST_SAMP;
                    if (b_go) pend_b_d = 1'b1;
                end else if (b_go) begin
                    grp_d      = GRP_B;
                    ch_d       = first_b;
                    enter_samp = 1'b1;
                    state_d    = ST_SAMP;
                end
            end
            ST_SAMP: begin
                if (samp_expired) state_d = ST_START;
            end
            ST_START: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (core_done_i) begin
                    res_wr     = !((mode == MODE_DOUBLE) && dbl_ph_q);
                    res_wr_dbl = (mode == MODE_DOUBLE) && dbl_ph_q;
                    if ((grp_q == GRP_B) && pend_a_d) begin
                        // Pre-empt B: run A now, restart B from its first channel later.
                        grp_d      = GRP_A;
                        ch_d       = first_a;
                        pend_a_d   = 1'b0;
                        pend_b_d   = 1'b1;
                        enter_samp = 1'b1;
                        state_d    = ST_SAMP;
                    end else if (next_found) begin
                        ch_d       = next_ch;
                        enter_samp = 1'b1;
                        state_d    = ST_SAMP;
                    end else begin
                        if (grp_q == GRP_A) done_a_d = 1'b1;
                        else                done_b_d = 1'b1;
                        if (mode == MODE_DOUBLE) dbl_ph_d = !dbl_ph_q;
                        if ((grp_q == GRP_A) && (mode == MODE_CONT) && first_a_found) begin
                            ch_d       = first_a;
                            enter_samp = 1'b1;
                            state_d    = ST_SAMP;
                        end else if ((grp_q == GRP_A) && pend_b_d && first_b_found) begin
                            grp_d      = GRP_B;
                            ch_d       = first_b;
                            pend_b_d   = 1'b0;
                            enter_samp = 1'b1;
                            state_d    = ST_SAMP;
                        end else begin
                            pend_a_d = 1'b0;
                            pend_b_d = 1'b0;
                            state_d  = ST_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            grp_q    <= GRP_A;
            ch_q     <= '0;
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
            dbl_ph_q <= 1'b0;
            done_a_q <= 1'b0;
            done_b_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            grp_q    <= grp_d;
            ch_q     <= ch_d;
            pend_a_q <= pend_a_d;
            pend_b_q <= pend_b_d;
            dbl_ph_q <= dbl_ph_d;
            done_a_q <= done_a_d;
            done_b_q <= done_b_d;
        end
    end

    assign core_start_o  = (state_q == ST_START);
    assign sample_o      = (state_q == ST_SAMP);
    assign busy_o        = (state_q != ST_IDLE);
    assign core_chan_o   = ch_q;
    assign scan_done_a_o = done_a_q;
    assign scan_done_b_o = done_b_q;

endmodule

// File: rtl/adc_scan_seq_checker.sv
// Protocol checker for the ADC scan sequencer, bound to the top module.
// Assumes: it sees only the top module's ports.
module adc_scan_seq_checker #(
    parameter int NCH   = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            sample_o,
    input logic            core_start_o,
    input logic            core_done_i,
    input logic [CH_W-1:0] core_chan_o,
    input logic            scan_done_a_o,
    input logic            scan_done_b_o
);

    logic in_flight_q;

    // Track whether a started conversion still awaits its done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight_q <= 1'b0;
        end else if (core_start_o) begin
            in_flight_q <= 1'b1;
        end else if (core_done_i) begin
            in_flight_q <= 1'b0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sample_o && !core_start_o)); // R1

    AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |=> !core_start_o); // R4

    AST_START_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |-> $past(sample_o)); // R4

    AST_CHAN_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && $past(sample_o)) |-> $stable(core_chan_o)); // R3

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scan_done_a_o, scan_done_b_o})); // R6

    AST_DONE_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done_a_o || scan_done_b_o) |-> $past(core_done_i)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_a_o |=> !scan_done_a_o); // R6

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |-> !in_flight_q); // R12

endmodule

bind adc_scan_seq adc_scan_seq_checker #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .sample_o      (sample_o),
    .core_start_o  (core_start_o),
    .core_done_i   (core_done_i),
    .core_chan_o   (core_chan_o),
    .scan_done_a_o (scan_done_a_o),
    .scan_done_b_o (scan_done_b_o)
);

// File: tb/adc_scan_seq_tb.sv
// Self-checking bench: behavioural converter core, random and directed scans.
module adc_scan_seq_tb;

    localparam int NCH      = 8;
    localparam int RES_W    = 12;
    localparam int SAMP_W   = 8;
    localparam int CH_W     = 3;
    localparam int CONV_LAT = 3;
    localparam int LOG_MAX  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]            mode_i = '0;
    logic [NCH-1:0]        chan_en_a_i = '0;
    logic [NCH-1:0]        chan_en_b_i = '0;
    logic [CH_W-1:0]       dbl_chan_i = '0;
    logic [NCH*SAMP_W-1:0] samp_time_i = '0;
    logic [1:0]            trig_src_a_i = '0;
    logic [1:0]            trig_src_b_i = 2'd3;
    logic                  sw_trig_i = 1'b0;
    logic                  tmr_trig_i = 1'b0;
    logic                  ext_trig_i = 1'b0;
    logic                  core_done_i = 1'b0;
    logic [RES_W-1:0]      core_result_i = '0;
    logic                  core_start_o, sample_o, busy_o;
    logic                  scan_done_a_o, scan_done_b_o;
    logic [CH_W-1:0]       core_chan_o;
    logic [NCH*RES_W-1:0]  res_data_o;
    logic [RES_W-1:0]      res_dbl_o;

    adc_scan_seq #(.NCH(NCH), .RES_W(RES_W), .SAMP_W(SAMP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .chan_en_a_i(chan_en_a_i), .chan_en_b_i(chan_en_b_i),
        .dbl_chan_i(dbl_chan_i), .samp_time_i(samp_time_i),
        .trig_src_a_i(trig_src_a_i), .trig_src_b_i(trig_src_b_i),
        .sw_trig_i(sw_trig_i), .tmr_trig_i(tmr_trig_i), .ext_trig_i(ext_trig_i),
        .core_start_o(core_start_o), .core_chan_o(core_chan_o),
        .core_done_i(core_done_i), .core_result_i(core_result_i),
        .sample_o(sample_o), .busy_o(busy_o),
        .scan_done_a_o(scan_done_a_o), .scan_done_b_o(scan_done_b_o),
        .res_data_o(res_data_o), .res_dbl_o(res_dbl_o)
    );

    int checks = 0;
    int errors = 0;
    int samp [NCH];
    int exp_res [NCH];
    int exp_dbl = 0;
    bit b_dbl_ph = 1'b0;
    int log_ch [LOG_MAX];
    int samp_log [LOG_MAX];
    int log_n = 0;
    int exp_seq [LOG_MAX];
    int exp_n = 0;
    int samp_run = 0;
    int conv_idx = 0;
    int lat_cnt = 0;
    int m_ch = 0;
    logic [RES_W-1:0] m_val = '0;
    int overlap = 0;
    int done_a_cnt = 0;
    int done_b_cnt = 0;
    int ord [16];
    int ord_n = 0;
    int seed_v;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural converter core and output monitor, all on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            core_done_i = 1'b0;
            lat_cnt = 0;
            samp_run = 0;
        end else begin
            core_done_i = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    core_done_i = 1'b1;
                    core_result_i = m_val;
                    if (mode_i == 2'd3 && b_dbl_ph) exp_dbl = int'(m_val);
                    else exp_res[m_ch] = int'(m_val);
                    if (mode_i == 2'd3) b_dbl_ph = !b_dbl_ph;
                end
            end
            if (sample_o) samp_run++;
            if (core_start_o) begin
                if (lat_cnt != 0) overlap++;
                m_ch = int'(core_chan_o);
                conv_idx++;
                m_val = RES_W'(m_ch * 193 + conv_idx * 29 + 5);
                lat_cnt = CONV_LAT;
                if (log_n < LOG_MAX) begin
                    log_ch[log_n] = m_ch;
                    samp_log[log_n] = samp_run;
                    log_n++;
                end
                samp_run = 0;
            end
            if (scan_done_a_o) begin
                done_a_cnt++;
                if (ord_n < 16) begin ord[ord_n] = 0; ord_n++; end
            end
            if (scan_done_b_o) begin
                done_b_cnt++;
                if (ord_n < 16) begin ord[ord_n] = 1; ord_n++; end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic clear_log();
        log_n = 0; exp_n = 0; done_a_cnt = 0; done_b_cnt = 0; ord_n = 0; samp_run = 0;
    endtask

    task automatic push_prefix(input logic [NCH-1:0] m, input int k);
        int taken = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m[c] && taken < k) begin
                exp_seq[exp_n] = c; exp_n++; taken++;
            end
        end
    endtask

    task automatic push_pass(input logic [NCH-1:0] m);
        push_prefix(m, NCH);
    endtask

    task automatic set_samp(input int maxv);
        for (int c = 0; c < NCH; c++) begin
            samp[c] = $urandom_range(0, maxv);
            samp_time_i[c*SAMP_W +: SAMP_W] = SAMP_W'(samp[c]);
        end
    endtask

    task automatic pulse(input bit s, input bit t, input bit e);
        @(negedge clk);
        sw_trig_i = s; tmr_trig_i = t; ext_trig_i = e;
        @(negedge clk);
        sw_trig_i = 1'b0; tmr_trig_i = 1'b0; ext_trig_i = 1'b0;
    endtask

    task automatic pulse_src(input int src);
        pulse(src == 0, src == 1, src == 2);
    endtask

    task automatic wait_idle();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (busy_o && t < 5000);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_seq(input string req);
        int bad = -1;
        chk(log_n == exp_n, req, "conversion count", log_n, exp_n);
        for (int i = 0; i < log_n && i < exp_n; i++) begin
            if (bad < 0 && log_ch[i] != exp_seq[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, req, "channel order at first mismatch", log_ch[bad], exp_seq[bad]);
        else chk(1'b1, req, "channel order", 0, 0);
    endtask

    task automatic cmp_samp();
        int bad = -1;
        for (int i = 0; i < log_n; i++) begin
            if (bad < 0 && samp_log[i] != samp[log_ch[i]] + 1) bad = i;
        end
        if (bad >= 0) chk(1'b0, "R4", "sampling cycles", samp_log[bad], samp[log_ch[bad]] + 1);
        else chk(1'b1, "R4", "sampling cycles", 0, 0);
    endtask

    task automatic cmp_res();
        int bad = -1;
        for (int c = 0; c < NCH; c++) begin
            if (bad < 0 && int'(res_data_o[c*RES_W +: RES_W]) != exp_res[c]) bad = c;
        end
        if (bad >= 0) chk(1'b0, "R5", "result slot", res_data_o[bad*RES_W +: RES_W], exp_res[bad]);
        else chk(1'b1, "R5", "result slots", 0, 0);
    endtask

    initial begin : stim
        logic [NCH-1:0] m;
        int src;
        int saved;
        bit dropped;
        seed_v = $urandom(32'd7531);
        for (int c = 0; c < NCH; c++) begin samp[c] = 0; exp_res[c] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !sample_o && !core_start_o, "R1", "busy/sample/start after reset", busy_o, 0);
        chk(!scan_done_a_o && !scan_done_b_o, "R1", "scan done after reset", scan_done_a_o, 0);
        chk(res_data_o == '0 && res_dbl_o == '0, "R1", "results after reset", res_data_o[RES_W-1:0], 0);

        // R2: only the selected source starts a scan
        set_samp(3);
        mode_i = 2'd0; chan_en_a_i = 8'h05; trig_src_a_i = 2'd1;
        clear_log();
        pulse(1, 0, 1);
        repeat (15) @(negedge clk);
        chk(log_n == 0 && !busy_o, "R2", "unselected sources ignored", log_n, 0);
        pulse_src(1);
        wait_idle();
        chk(log_n == 2, "R2", "selected timer source starts", log_n, 2);
        trig_src_a_i = 2'd3;
        clear_log();
        pulse(1, 1, 1);
        repeat (15) @(negedge clk);
        chk(log_n == 0, "R2", "source code 3 disables", log_n, 0);

        // R3..R6, R8: directed corners then random single scans
        for (int it = 0; it < 9; it++) begin
            if (it == 0) m = 8'h80;
            else if (it == 1) m = 8'h01;
            else if (it == 2) m = 8'hFF;
            else m = NCH'($urandom_range(1, 255));
            set_samp(6);
            src = $urandom_range(0, 2);
            mode_i = 2'd0; chan_en_a_i = m; trig_src_a_i = 2'(src);
            clear_log();
            push_pass(m);
            pulse_src(src);
            if (it % 2 == 1) begin
                repeat (3) @(negedge clk);
                pulse_src(src); // R8: same-group retrigger while busy
            end
            wait_idle();
            cmp_seq("R3");
            cmp_samp();
            cmp_res();
            chk(done_a_cnt == 1 && done_b_cnt == 0, "R6", "one scan-done pulse", done_a_cnt, 1);
            repeat (20) @(negedge clk);
            chk(log_n == exp_n && !busy_o, "R6", "single mode stays idle", log_n, exp_n);
        end

        // R8: empty set ignored
        chan_en_a_i = '0; trig_src_a_i = 2'd0;
        clear_log();
        pulse_src(0);
        repeat (15) @(negedge clk);
        chk(log_n == 0 && !busy_o, "R8", "trigger with empty set", log_n, 0);

        // R7: continuous mode wraps without idle, stops after mode change
        set_samp(4);
        m = 8'h29;
        mode_i = 2'd1; chan_en_a_i = m; trig_src_a_i = 2'd2;
        clear_log();
        push_pass(m); push_pass(m); push_pass(m);
        pulse_src(2);
        dropped = 1'b0;
        for (int t = 0; t < 3000 && done_a_cnt < 2; t++) begin
            @(negedge clk);
            if (!busy_o) dropped = 1'b1;
        end
        mode_i = 2'd0;
        wait_idle();
        chk(!dropped, "R7", "no idle between passes", dropped, 0);
        cmp_seq("R7");
        chk(done_a_cnt == 3, "R7", "passes before stop", done_a_cnt, 3);

        // R9: B trigger during A is queued
        set_samp(3);
        mode_i = 2'd2; chan_en_a_i = 8'h0C; chan_en_b_i = 8'h61;
        trig_src_a_i = 2'd0; trig_src_b_i = 2'd2;
        clear_log();
        push_pass(8'h0C); push_pass(8'h61);
        pulse_src(0);
        repeat (3) @(negedge clk);
        pulse_src(2);
        wait_idle();
        cmp_seq("R9");
        chk(ord_n == 2 && ord[0] == 0 && ord[1] == 1, "R9", "done order A then B", ord[0], 0);

        // R9: simultaneous triggers run A first
        clear_log();
        push_pass(8'h0C); push_pass(8'h61);
        pulse(1, 0, 1);
        wait_idle();
        cmp_seq("R9");
        cmp_res();

        // R10: A pre-empts B mid-pass and on B's last channel
        for (int k = 2; k <= 4; k += 2) begin
            set_samp(2);
            chan_en_a_i = 8'h03; chan_en_b_i = 8'hB4;
            clear_log();
            push_prefix(8'hB4, k); push_pass(8'h03); push_pass(8'hB4);
            pulse_src(2);
            for (int t = 0; t < 2000 && log_n < k; t++) @(negedge clk);
            pulse_src(0);
            wait_idle();
            cmp_seq("R10");
            chk(done_b_cnt == 1 && done_a_cnt == 1, "R10", "B done only for full pass", done_b_cnt, 1);
            chk(ord_n == 2 && ord[0] == 0 && ord[1] == 1, "R10", "done order A then B", ord[0], 0);
            cmp_res();
        end

        // R11: double-trigger mode keeps two results
        trig_src_b_i = 2'd3;
        mode_i = 2'd3; dbl_chan_i = 3'd5; trig_src_a_i = 2'd1;
        b_dbl_ph = 1'b0;
        clear_log();
        pulse_src(1);
        wait_idle();
        saved = exp_res[5];
        chk(log_n == 1 && log_ch[0] == 5, "R11", "converted channel", log_ch[0], 5);
        chk(int'(res_data_o[5*RES_W +: RES_W]) == saved, "R11", "first result", res_data_o[5*RES_W +: RES_W], saved);
        pulse_src(1);
        wait_idle();
        chk(int'(res_dbl_o) == exp_dbl, "R11", "second result", res_dbl_o, exp_dbl);
        chk(int'(res_data_o[5*RES_W +: RES_W]) == saved, "R11", "first result kept", res_data_o[5*RES_W +: RES_W], saved);
        chk(done_a_cnt == 2, "R11", "done per conversion", done_a_cnt, 2);

        // R12: never two conversions in flight
        chk(overlap == 0, "R12", "overlapping starts", overlap, 0);

        summary();
        $finish;
    end

endmodule